// File: doc/BRIEF.md
# Downstream Port Reset and Connect Sequencer

This block is the control machine for one downstream port of a hub. It reads the port's sampled line state, debounces device attach and detach, and drives single-ended zero onto the port when a port reset is asked for. When the hub is the root of the tree, one reset is built as a chain of separate pulses with short idle gaps between them, so the total reset time reaches the longer root requirement. On command it also drives the K state downstream to wake a suspended device. All timing is counted in clock cycles set by parameters. The defaults are scaled down so that the bench runs quickly. A real instance sets them from the core clock: a connect window of at least 2.5 µs, a disconnect window between 2 µs and 2.5 µs, reset pulses of 10 to 20 ms, root gaps of at most 3 ms, at least 50 ms of total root reset, and 20 ms of resume.

Every pin is a plain control or status level or pulse. No data stream passes through the block, so no valid/ready handshake is involved. A request is sampled on a clock edge and is acted on only while the port is connected and the sequencer is idle.

Top module: `dnport_seq`

## Requirements
- R1: After reset, `port_conn`, `drv_se0`, `drv_k`, `rst_done` and `rsm_done` are all 0.
- R2: Line encoding is 00 = SE0, 01 = J, 10 = K, and 11 counts as non-SE0. While disconnected, `port_conn` rises after `CONN_DB` consecutive sampled non-SE0 cycles. A single SE0 sample restarts the count.
- R3: While connected and not driving SE0, `port_conn` falls after `DISC_DB` consecutive sampled SE0 cycles. A shorter SE0 run has no effect.
- R4: With `root_mode` = 0, a reset request drives `drv_se0` for exactly `RST_LEN` cycles. `rst_done` is then high for one cycle, in the first cycle after the pulse.
- R5: With `root_mode` = 1 at request time, the reset is `ROOT_PULSES` pulses of `RST_LEN` cycles each, separated by idle gaps of exactly `GAP_LEN` cycles. `rst_done` pulses once, only after the last pulse.
- R6: A resume request drives `drv_k` for exactly `RSM_LEN` cycles, then pulses `rsm_done` for one cycle.
- R7: Reset and resume requests are ignored while the port is disconnected or while a sequence is running.
- R8: If reset and resume are requested in the same cycle, reset is taken.
- R9: A disconnect during a reset gap or during resume aborts the sequence. Both drives stop on the next cycle and no completion pulse is given.
- R10: `drv_se0` and `drv_k` are never high together, and completion pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_st | input | 2 | Sampled line state (00 SE0, 01 J, 10 K) |
| rst_req | input | 1 | Port reset request |
| rsm_req | input | 1 | Resume request |
| root_mode | input | 1 | 1 builds the multi-pulse root reset |
| drv_se0 | output | 1 | Drive SE0 onto the port |
| drv_k | output | 1 | Drive K onto the port |
| port_conn | output | 1 | Debounced connected status |
| rst_done | output | 1 | One-cycle reset completion pulse |
| rsm_done | output | 1 | One-cycle resume completion pulse |

## Verification
On every cycle, the bound checker checks that the two drives are exclusive, that no SE0 pulse or K run outlasts its length, that each completion pulse follows the matching drive, that a connect follows non-SE0 line samples, and that drives stop right after a disconnect. Only the directed scenarios can show the exact debounce counts and the restart after a single SE0 sample, the exact gap lengths and pulse count of the root reset, that requests are ignored while busy or detached, the reset-over-resume priority, and that aborts never yield a completion pulse.

// File: rtl/dnport_pkg.sv
package dnport_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RST,
    SQ_GAP,
    SQ_RSM
  } seq_st_t;
endpackage

// File: rtl/dnport_link_detect.sv
module dnport_link_detect #(
  parameter int CONN_DB = 40,
  parameter int DISC_DB = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_st,
  input  logic       own_se0,
  output logic       conn
);
  import dnport_pkg::*;
  localparam int DBMAX = (CONN_DB > DISC_DB) ? CONN_DB : DISC_DB;
  localparam int W     = $clog2(DBMAX + 1);

  logic [W-1:0] cnt;
  logic         is_se0;

  assign is_se0 = (line_st == LS_SE0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn <= 1'b0;
      cnt  <= '0;
    end else if (!conn) begin
      if (is_se0) begin
        cnt <= '0;
      end else if (cnt == W'(CONN_DB - 1)) begin
        conn <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      // our own SE0 drive hides the device's pull, so the count is held off
      if (!is_se0 || own_se0) begin
        cnt <= '0;
      end else if (cnt == W'(DISC_DB - 1)) begin
        conn <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dnport_drive_seq.sv
module dnport_drive_seq #(
  parameter int RST_LEN     = 100,
  parameter int GAP_LEN     = 12,
  parameter int ROOT_PULSES = 5,
  parameter int RSM_LEN     = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conn,
  input  logic rst_req,
  input  logic rsm_req,
  input  logic root_mode,
  output logic drv_se0,
  output logic drv_k,
  output logic rst_done,
  output logic rsm_done
);
  import dnport_pkg::*;
  localparam int M1   = (RST_LEN > GAP_LEN) ? RST_LEN : GAP_LEN;
  localparam int TMAX = (M1 > RSM_LEN) ? M1 : RSM_LEN;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(ROOT_PULSES + 1);

  seq_st_t       st;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pcnt;
  logic [PW-1:0] tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      tmr      <= '0;
      pcnt     <= '0;
      tgt      <= '0;
      rst_done <= 1'b0;
      rsm_done <= 1'b0;
    end else begin
      rst_done <= 1'b0;
      rsm_done <= 1'b0;
      if (st != SQ_IDLE && !conn) begin
        st  <= SQ_IDLE;
        tmr <= '0;
      end else begin
        case (st)
          SQ_IDLE: begin
            tmr  <= '0;
            pcnt <= '0;
            if (conn && rst_req) begin
              st  <= SQ_RST;
              tgt <= root_mode ? PW'(ROOT_PULSES - 1) : '0;
            end else if (conn && rsm_req) begin
              st <= SQ_RSM;
            end
          end
          SQ_RST: begin
            if (tmr == TW'(RST_LEN - 1)) begin
              tmr <= '0;
              if (pcnt == tgt) begin
                st       <= SQ_IDLE;
                rst_done <= 1'b1;
              end else begin
                st   <= SQ_GAP;
                pcnt <= pcnt + 1'b1;
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          SQ_GAP: begin
            if (tmr == TW'(GAP_LEN - 1)) begin
              tmr <= '0;
              st  <= SQ_RST;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          SQ_RSM: begin
            if (tmr == TW'(RSM_LEN - 1)) begin
              tmr      <= '0;
              st       <= SQ_IDLE;
              rsm_done <= 1'b1;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end

  assign drv_se0 = (st == SQ_RST);
  assign drv_k   = (st == SQ_RSM);
endmodule

// File: rtl/dnport_seq.sv
module dnport_seq #(
  parameter int CONN_DB     = 40,
  parameter int DISC_DB     = 6,
  parameter int RST_LEN     = 100,
  parameter int GAP_LEN     = 12,
  parameter int ROOT_PULSES = 5,
  parameter int RSM_LEN     = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_st,
  input  logic       rst_req,
  input  logic       rsm_req,
  input  logic       root_mode,
  output logic       drv_se0,
  output logic       drv_k,
  output logic       port_conn,
  output logic       rst_done,
  output logic       rsm_done
);
  dnport_link_detect #(
    .CONN_DB(CONN_DB),
    .DISC_DB(DISC_DB)
  ) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_st(line_st),
    .own_se0(drv_se0),
    .conn   (port_conn)
  );

  dnport_drive_seq #(
    .RST_LEN    (RST_LEN),
    .GAP_LEN    (GAP_LEN),
    .ROOT_PULSES(ROOT_PULSES),
    .RSM_LEN    (RSM_LEN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .conn     (port_conn),
    .rst_req  (rst_req),
    .rsm_req  (rsm_req),
    .root_mode(root_mode),
    .drv_se0  (drv_se0),
    .drv_k    (drv_k),
    .rst_done (rst_done),
    .rsm_done (rsm_done)
  );
endmodule

// File: rtl/dnport_seq_chk.sv
module dnport_seq_chk #(
  parameter int RST_LEN = 100,
  parameter int RSM_LEN = 160
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] line_st,
  input logic       drv_se0,
  input logic       drv_k,
  input logic       port_conn,
  input logic       rst_done,
  input logic       rsm_done
);
  localparam int W = $clog2(((RST_LEN > RSM_LEN) ? RST_LEN : RSM_LEN) + 2);
  logic [W-1:0] se0_run;
  logic [W-1:0] k_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se0_run <= '0;
      k_run   <= '0;
    end else begin
      se0_run <= drv_se0 ? se0_run + 1'b1 : '0;
      k_run   <= drv_k ? k_run + 1'b1 : '0;
    end
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_se0 && drv_k));
  p_done_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_done, rsm_done}));
  p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drv_se0 |-> (se0_run < W'(RST_LEN)));
  p_rsm_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_k |-> (k_run < W'(RSM_LEN)));
  p_rst_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |-> ($past(drv_se0) && !drv_se0));
  p_rsm_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsm_done |-> ($past(drv_k) && !drv_k));
  p_conn_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_conn) |-> ($past(line_st) != 2'b00));
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_conn) |=> (!drv_se0 && !drv_k && !rst_done && !rsm_done));
endmodule

bind dnport_seq dnport_seq_chk #(
  .RST_LEN(RST_LEN),
  .RSM_LEN(RSM_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_st  (line_st),
  .drv_se0  (drv_se0),
  .drv_k    (drv_k),
  .port_conn(port_conn),
  .rst_done (rst_done),
  .rsm_done (rsm_done)
);

// File: tb/sim_dnport_seq.sv
`timescale 1ns/1ps
module sim_dnport_seq;
  localparam int CONN_DB = 40, DISC_DB = 6, RST_LEN = 100, GAP_LEN = 12;
  localparam int ROOT_PULSES = 5, RSM_LEN = 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] line_st = 2'b00;
  logic rst_req = 1'b0, rsm_req = 1'b0, root_mode = 1'b0;
  logic drv_se0, drv_k, port_conn, rst_done, rsm_done;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dnport_seq #(.CONN_DB(CONN_DB), .DISC_DB(DISC_DB), .RST_LEN(RST_LEN),
    .GAP_LEN(GAP_LEN), .ROOT_PULSES(ROOT_PULSES), .RSM_LEN(RSM_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .line_st(line_st), .rst_req(rst_req),
    .rsm_req(rsm_req), .root_mode(root_mode), .drv_se0(drv_se0),
    .drv_k(drv_k), .port_conn(port_conn), .rst_done(rst_done),
    .rsm_done(rsm_done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_se0(output int n);
    n = 0;
    while (drv_se0 && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic make_conn();
    line_st = 2'b01;
    repeat (CONN_DB + 1) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(!port_conn && !drv_se0 && !drv_k && !rst_done && !rsm_done, "R1 reset state",
        {port_conn, drv_se0, drv_k, rst_done, rsm_done}, 0);
  endtask

  task automatic t_ignore_detached();
    int seen = 0;
    rst_req = 1'b1; rsm_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0; rsm_req = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (drv_se0 || drv_k || rst_done || rsm_done) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R7 request ignored while detached", seen, 0);
  endtask

  task automatic t_connect();
    line_st = 2'b01;
    repeat (CONN_DB - 2) @(negedge clk);
    line_st = 2'b00;
    @(negedge clk);
    line_st = 2'b10;
    repeat (CONN_DB - 1) @(negedge clk);
    chk(port_conn == 1'b0, "R2 count restarts after SE0", port_conn, 0);
    @(negedge clk);
    chk(port_conn == 1'b1, "R2 connect after full debounce", port_conn, 1);
    line_st = 2'b01;
  endtask

  task automatic t_reset_normal();
    int n;
    root_mode = 1'b0;
    rst_req = 1'b1; @(negedge clk); rst_req = 1'b0;
    run_se0(n);
    chk(n == RST_LEN, "R4 single pulse length", n, RST_LEN);
    chk(rst_done == 1'b1, "R4 done after pulse", rst_done, 1);
    @(negedge clk);
    chk(rst_done == 1'b0, "R10 done lasts one cycle", rst_done, 0);
  endtask

  task automatic t_reset_root();
    int n, g, sum = 0, gbad = 0, dbad = 0;
    root_mode = 1'b1;
    rst_req = 1'b1; @(negedge clk); rst_req = 1'b0; root_mode = 1'b0;
    for (int p = 0; p < ROOT_PULSES; p++) begin
      run_se0(n);
      sum += n;
      if (p < ROOT_PULSES - 1) begin
        if (rst_done) dbad++;
        g = 0;
        while (!drv_se0 && g < 1000) begin g++; @(negedge clk); end
        if (g != GAP_LEN) gbad++;
      end
    end
    chk(sum == ROOT_PULSES * RST_LEN, "R5 total root SE0", sum, ROOT_PULSES * RST_LEN);
    chk(gbad == 0, "R5 gap lengths", gbad, 0);
    chk(dbad == 0, "R5 no early done", dbad, 0);
    chk(rst_done == 1'b1, "R5 done after last pulse", rst_done, 1);
    @(negedge clk);
  endtask

  task automatic t_resume_busy();
    int n = 0, se0 = 0;
    rsm_req = 1'b1; @(negedge clk); rsm_req = 1'b0;
    while (drv_k && n < 2000) begin
      rst_req = (n == 3);
      if (drv_se0) se0++;
      n++; @(negedge clk);
    end
    rst_req = 1'b0;
    chk(n == RSM_LEN, "R6 resume length", n, RSM_LEN);
    chk(rsm_done == 1'b1, "R6 resume done", rsm_done, 1);
    @(negedge clk);
    chk(se0 == 0 && !drv_se0, "R7 reset ignored while busy", se0, 0);
  endtask

  task automatic t_priority();
    int n;
    rst_req = 1'b1; rsm_req = 1'b1; @(negedge clk); rst_req = 1'b0; rsm_req = 1'b0;
    chk(drv_se0 && !drv_k, "R8 reset wins / R10 exclusive", {drv_se0, drv_k}, 2);
    run_se0(n);
    chk(n == RST_LEN, "R8 reset completes", n, RST_LEN);
    @(negedge clk);
  endtask

  task automatic t_abort_resume();
    int n = 0, dn = 0;
    rsm_req = 1'b1; @(negedge clk); rsm_req = 1'b0;
    while (drv_k && n < 2000) begin
      if (n == 10) line_st = 2'b00;
      if (rsm_done) dn++;
      n++; @(negedge clk);
    end
    for (int i = 0; i < 5; i++) begin
      if (rsm_done || drv_k) dn++;
      @(negedge clk);
    end
    chk(n == 10 + DISC_DB + 1, "R9 resume aborted on disconnect", n, 10 + DISC_DB + 1);
    chk(dn == 0 && !port_conn, "R9 no resume done after abort", dn, 0);
    make_conn();
  endtask

  task automatic t_abort_gap();
    int n, sn = 0;
    root_mode = 1'b1;
    rst_req = 1'b1; @(negedge clk); rst_req = 1'b0; root_mode = 1'b0;
    run_se0(n);
    line_st = 2'b00;
    for (int i = 0; i < 40; i++) begin
      if (drv_se0 || rst_done) sn++;
      @(negedge clk);
    end
    chk(sn == 0, "R9 root reset aborted in gap", sn, 0);
    chk(port_conn == 1'b0, "R9 status cleared", port_conn, 0);
    make_conn();
  endtask

  task automatic t_disconnect();
    line_st = 2'b00;
    repeat (DISC_DB - 1) @(negedge clk);
    line_st = 2'b01;
    repeat (3) @(negedge clk);
    chk(port_conn == 1'b1, "R3 short SE0 ignored", port_conn, 1);
    line_st = 2'b00;
    repeat (DISC_DB - 1) @(negedge clk);
    chk(port_conn == 1'b1, "R3 still up before window", port_conn, 1);
    @(negedge clk);
    chk(port_conn == 1'b0, "R3 disconnect after window", port_conn, 0);
  endtask

  initial begin
    #(150000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_ignore_detached();
    t_connect();
    t_reset_normal();
    t_reset_root();
    t_resume_busy();
    t_priority();
    t_abort_resume();
    t_abort_gap();
    t_disconnect();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule